// File: doc/BRIEF.md
# Bit-Manipulation ALU with Flags

This block performs five bit-manipulation operations on a 64-bit or 32-bit operand lane and produces a result with four condition flags. The operations are: AND-NOT of two operands, extraction of a bit field, isolation of the lowest set bit, building a mask up to and including the lowest set bit, and clearing the lowest set bit. Each operation has its own rule for the zero, sign, carry and overflow flags.

A caller presents an operation code, a width select and two operands with `in_valid` high for one cycle. The result and flags appear on the registered outputs one clock later, marked by `out_valid`. Between requests the outputs hold their last value. The second operand is a data word for AND-NOT. For field extraction it is a control word: the start position is in bits [7:0] and the field length is in bits [15:8].

Top module: `bma_core`

## Requirements
- R1: Op code 0 (AND-NOT) gives `~src_a & src_b`. The zero flag is set when the result is 0, and the sign flag copies the top bit of the lane. Carry is 0.
- R2: Op code 1 (field extract) reads the start from `src_b[7:0]` and the length from `src_b[15:8]`. The result is `src_a` shifted right by the start and then masked to its low `length` bits.
- R3: For field extract, a start at or beyond the lane width gives 0. A length at or beyond the lane width keeps every remaining bit. A length of 0 gives 0.
- R4: For field extract, the zero flag is set when the result is 0, and the sign and carry flags are 0.
- R5: Op code 2 (isolate lowest) gives `-x & x`, with zero and sign taken from the result. Carry is 1 exactly when x is nonzero.
- R6: Op code 3 (mask to lowest) gives `(x-1) ^ x`, with sign taken from the result. Carry is 1 exactly when x is zero, and the zero flag is always 0. For x = 0 the result is all ones across the lane.
- R7: Op code 4 (clear lowest) gives `(x-1) & x`, with zero and sign taken from the result. Carry is 1 exactly when x is zero.
- R8: With `wide_sel` = 0 the lane is 32 bits wide. Only the low 32 bits of both operands are used, the sign flag comes from result bit 31, and result bits [63:32] are 0. With `wide_sel` = 1 the lane is 64 bits wide and the sign flag comes from bit 63.
- R9: The result and flags appear one cycle after a cycle with `in_valid` high, together with `out_valid` = 1. In a cycle after `in_valid` low, `out_valid` is 0 and the outputs hold their last values.
- R10: While `rst_n` is low, `out_valid`, the result and all flags are 0, whatever the inputs are.
- R11: Op codes 5, 6 and 7 give a result of 0 with all flags at 0.
- R12: The overflow flag is 0 after every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is presented in this cycle |
| op_sel | input | 3 | Operation code (0 to 4 valid) |
| wide_sel | input | 1 | 1 = 64-bit lane, 0 = 32-bit lane |
| src_a | input | 64 | Primary operand |
| src_b | input | 64 | Second operand, or the extract control word |
| out_valid | output | 1 | Result and flags belong to the request of the previous cycle |
| result | output | 64 | Operation result |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the hold of the outputs while idle;
- a zero upper half in 32-bit mode;
- the structural properties of the results: a one-hot isolate result whose carry tracks nonzero, a nonzero mask result with the zero flag clear, a clear-lowest result with exactly one bit fewer, and an AND-NOT result that never leaves the second operand;
- clear sign and carry on extraction, and the zero result of unused op codes.

Exact result values can only be shown by the bench's scenarios, which compare each request against a bit-by-bit behavioural model. These scenarios cover:
- the extract boundaries: the start at or beyond the lane, an oversized length, and a length of zero;
- operands of zero and of top-bit only;
- garbage in the upper half of the operands in 32-bit mode;
- inputs driven during reset.

// File: rtl/bma_pkg.sv
package bma_pkg;

    // Width of each byte-sized field in the extract control word
    localparam int FIELD_W = 8;

    typedef enum logic [2:0] {
        OP_ANDNOT   = 3'd0,
        OP_FIELD    = 3'd1,
        OP_ISOLATE  = 3'd2,
        OP_MASKLOW  = 3'd3,
        OP_CLEARLOW = 3'd4
    } op_e;

    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
        logic ovf;
    } flags_t;

endpackage

// File: rtl/bma_field_extract.sv
module bma_field_extract
    import bma_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]    src,
    input  logic [2*FIELD_W-1:0] ctl,
    input  logic                 wide,
    output logic [DATA_W-1:0]    field
);
    localparam int NARROW_W = DATA_W / 2;
    localparam int POS_W    = $clog2(DATA_W);
    localparam logic [FIELD_W:0] LIM_WIDE   = (FIELD_W+1)'(DATA_W);
    localparam logic [FIELD_W:0] LIM_NARROW = (FIELD_W+1)'(NARROW_W);
    localparam logic [DATA_W-1:0] LANE_NARROW = {{NARROW_W{1'b0}}, {NARROW_W{1'b1}}};

    logic [FIELD_W-1:0] start_pos;
    logic [FIELD_W-1:0] span;
    logic [FIELD_W:0]   limit;
    logic [DATA_W-1:0]  lane_mask;
    logic [DATA_W-1:0]  shifted;
    logic [DATA_W-1:0]  keep;

    always_comb begin
        start_pos = ctl[FIELD_W-1:0];
        span      = ctl[2*FIELD_W-1:FIELD_W];
        limit     = wide ? LIM_WIDE : LIM_NARROW;
        lane_mask = wide ? '1 : LANE_NARROW;

        // A start past the lane leaves nothing to extract
        if ({1'b0, start_pos} >= limit)
            shifted = '0;
        else
            shifted = (src & lane_mask) >> start_pos[POS_W-1:0];

        // An oversized length saturates to the full lane
        if ({1'b0, span} >= limit)
            keep = lane_mask;
        else
            keep = ((DATA_W'(1) << span[POS_W-1:0]) - DATA_W'(1)) & lane_mask;

        field = shifted & keep;
    end

endmodule

// File: rtl/bma_lowbit.sv
module bma_lowbit #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] x,
    input  logic              wide,
    output logic [DATA_W-1:0] isolated,
    output logic [DATA_W-1:0] lowmask,
    output logic [DATA_W-1:0] cleared
);
    localparam int NARROW_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LANE_NARROW = {{NARROW_W{1'b0}}, {NARROW_W{1'b1}}};

    logic [DATA_W-1:0] dec;
    logic [DATA_W-1:0] neg;
    logic [DATA_W-1:0] lane_mask;

    always_comb begin
        lane_mask = wide ? '1 : LANE_NARROW;
        dec       = x - DATA_W'(1);
        neg       = ~x + DATA_W'(1);
        isolated  = neg & x;
        // x = 0 borrows through every bit: confine the ones to the lane
        lowmask   = (dec ^ x) & lane_mask;
        cleared   = dec & x;
    end

endmodule

// File: rtl/bma_flag_gen.sv
module bma_flag_gen
    import bma_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  op_e               op,
    input  logic              wide,
    input  logic [DATA_W-1:0] res,
    input  logic              src_zero,
    output flags_t            flags
);
    localparam int NARROW_W = DATA_W / 2;

    logic res_zero;
    logic res_top;

    always_comb begin
        res_zero = (res == '0);
        res_top  = wide ? res[DATA_W-1] : res[NARROW_W-1];
        flags    = '0;
        unique case (op)
            OP_ANDNOT: begin
                flags.zero = res_zero;
                flags.sign = res_top;
            end
            OP_FIELD: begin
                flags.zero = res_zero;
            end
            OP_ISOLATE: begin
                flags.zero  = res_zero;
                flags.sign  = res_top;
                flags.carry = ~src_zero;
            end
            OP_MASKLOW: begin
                flags.sign  = res_top;
                flags.carry = src_zero;
            end
            OP_CLEARLOW: begin
                flags.zero  = res_zero;
                flags.sign  = res_top;
                flags.carry = src_zero;
            end
            default: flags = '0;
        endcase
    end

endmodule

// File: rtl/bma_core.sv
module bma_core
    import bma_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic              wide_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_zero,
    output logic              flag_sign,
    output logic              flag_carry,
    output logic              flag_ovf
);
    localparam int NARROW_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LANE_NARROW = {{NARROW_W{1'b0}}, {NARROW_W{1'b1}}};

    op_e               op;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] a_n;
    logic [DATA_W-1:0] b_n;
    logic [DATA_W-1:0] field_res;
    logic [DATA_W-1:0] iso_res;
    logic [DATA_W-1:0] msk_res;
    logic [DATA_W-1:0] clr_res;
    logic [DATA_W-1:0] next_res;
    flags_t            next_flags;

    logic              valid_q;
    logic [DATA_W-1:0] res_q;
    flags_t            flags_q;

    // Operand narrowing to the selected lane
    always_comb begin
        op        = op_e'(op_sel);
        lane_mask = wide_sel ? '1 : LANE_NARROW;
        a_n       = src_a & lane_mask;
        b_n       = src_b & lane_mask;
    end

    bma_field_extract #(.DATA_W(DATA_W)) i_field (
        .src   (a_n),
        .ctl   (b_n[2*FIELD_W-1:0]),
        .wide  (wide_sel),
        .field (field_res)
    );

    bma_lowbit #(.DATA_W(DATA_W)) i_lowbit (
        .x        (a_n),
        .wide     (wide_sel),
        .isolated (iso_res),
        .lowmask  (msk_res),
        .cleared  (clr_res)
    );

    // Result selection
    always_comb begin
        unique case (op)
            OP_ANDNOT:   next_res = ~a_n & b_n;
            OP_FIELD:    next_res = field_res;
            OP_ISOLATE:  next_res = iso_res;
            OP_MASKLOW:  next_res = msk_res;
            OP_CLEARLOW: next_res = clr_res;
            default:     next_res = '0;
        endcase
    end

    bma_flag_gen #(.DATA_W(DATA_W)) i_flags (
        .op       (op),
        .wide     (wide_sel),
        .res      (next_res),
        .src_zero (a_n == '0),
        .flags    (next_flags)
    );

    // Single output register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q   <= next_res;
                flags_q <= next_flags;
            end
        end
    end

    always_comb begin
        out_valid  = valid_q;
        result     = res_q;
        flag_zero  = flags_q.zero;
        flag_sign  = flags_q.sign;
        flag_carry = flags_q.carry;
        flag_ovf   = flags_q.ovf;
    end

endmodule

// File: rtl/bma_core_chk.sv
module bma_core_chk
    import bma_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_sel,
    input logic              wide_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              flag_zero,
    input logic              flag_sign,
    input logic              flag_carry,
    input logic              flag_ovf
);
    localparam int NARROW_W = DATA_W / 2;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flag_zero) && $stable(flag_carry))); // R9
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_sel) |=> (result[DATA_W-1:NARROW_W] == '0)); // R8
    AST_ANDNOT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_sel && op_sel == OP_ANDNOT) |=> ((result & ~$past(src_b)) == '0 && (result & $past(src_a)) == '0)); // R1
    AST_FIELD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_FIELD) |=> (!flag_sign && !flag_carry)); // R4
    AST_FIELD_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_FIELD && src_b[15:8] == 8'd0) |=> (result == '0 && flag_zero)); // R3
    AST_ISO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_ISOLATE) |=> ($onehot0(result) && flag_carry == (result != '0))); // R5
    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_MASKLOW) |=> (!flag_zero && result != '0)); // R6
    AST_CLEAR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_sel && op_sel == OP_CLEARLOW && src_a != '0) |=> ($countones(result) == $countones($past(src_a)) - 1)); // R7
    AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel > 3'd4) |=> (result == '0 && !flag_zero && !flag_sign && !flag_carry)); // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !flag_ovf); // R12

endmodule

bind bma_core bma_core_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_bma_core.sv
`timescale 1ns/1ps
module test_bma_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        wide_sel = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        flag_zero, flag_sign, flag_carry, flag_ovf;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          mon_on = 1'b0;
    bit          have_last = 1'b0;
    bit          done = 1'b0;
    logic [67:0] last_obs;
    logic [67:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    bma_core i_bma_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .wide_sel(wide_sel), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .result(result), .flag_zero(flag_zero), .flag_sign(flag_sign),
        .flag_carry(flag_carry), .flag_ovf(flag_ovf)
    );

    // Behavioural model: {result, zero, sign, carry, ovf}
    function automatic logic [67:0] model(input logic [2:0] op, input logic wide,
                                          input logic [63:0] a, input logic [63:0] b);
        int w;
        int k;
        int st;
        int ln;
        logic [63:0] wm, am, bm, r;
        logic zf, sf, cf;
        w  = wide ? 64 : 32;
        wm = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        am = a & wm;
        bm = b & wm;
        r  = '0; zf = 1'b0; sf = 1'b0; cf = 1'b0;
        k  = -1;
        for (int i = w - 1; i >= 0; i--) if (am[i]) k = i;
        case (op)
            3'd0: begin r = ~am & bm & wm; zf = (r == 0); sf = r[w-1]; end
            3'd1: begin
                st = int'(b[7:0]); ln = int'(b[15:8]);
                for (int i = 0; i < w; i++) if (i < ln && st + i < w) r[i] = am[st+i];
                zf = (r == 0);
            end
            3'd2: begin if (k >= 0) r[k] = 1'b1; zf = (r == 0); sf = r[w-1]; cf = (k >= 0); end
            3'd3: begin
                if (k < 0) r = wm;
                else for (int i = 0; i <= k; i++) r[i] = 1'b1;
                sf = r[w-1]; cf = (k < 0);
            end
            3'd4: begin r = am; if (k >= 0) r[k] = 1'b0; zf = (r == 0); sf = r[w-1]; cf = (k < 0); end
            default: ;
        endcase
        return {r, zf, sf, cf, 1'b0};
    endfunction

    task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Driver: presents one request and pushes its expected item
    task automatic drive(input string tag, input logic [2:0] op, input logic wide,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; wide_sel = wide; src_a = a; src_b = b;
        exp_q.push_back(model(op, wide, a, b));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_a = {$urandom, $urandom};
        end
    endtask

    // Monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (mon_on) begin
            logic [67:0] obs;
            obs = {result, flag_zero, flag_sign, flag_carry, flag_ovf};
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R9 out_valid with no request", {67'b0, out_valid}, 68'b0);
                end else begin
                    check(tag_q.pop_front(), obs, exp_q.pop_front());
                end
                last_obs  = obs;
                have_last = 1'b1;
            end else if (have_last) begin
                check("R9 hold while idle", obs, last_obs);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R10: drive a live request while held in reset
        in_valid = 1'b1; op_sel = 3'd3; wide_sel = 1'b1; src_a = '0; src_b = '1;
        repeat (3) @(negedge clk);
        check("R10 reset state", {result, flag_zero, flag_sign, flag_carry, flag_ovf, out_valid},
              69'b0 >> 1);
        check("R10 out_valid in reset", {67'b0, out_valid}, 68'b0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        mon_on = 1'b1;
        idle(2);

        // R1, R12: AND-NOT
        drive("R1 R12 andnot mixed", 3'd0, 1'b1, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFFFF_0000_FFFF_0000);
        drive("R1 andnot zero", 3'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
        drive("R1 andnot sign", 3'd0, 1'b1, 64'h0, 64'h8000_0000_0000_0001);
        // R2: field extract
        drive("R2 field mid", 3'd1, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_1008);
        drive("R2 field top", 3'd1, 1'b1, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0000_083C);
        // R3: extract boundaries
        drive("R3 start at width", 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0840);
        drive("R3 start past narrow", 3'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0828);
        drive("R3 long length", 3'd1, 1'b1, 64'h8765_4321_0FED_CBA9, 64'h0000_0000_0000_C804);
        drive("R3 length exactly width", 3'd1, 1'b0, 64'hAAAA_AAAA_5555_5555, 64'h0000_0000_0000_2000);
        drive("R3 zero length", 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003);
        // R4: extract flags
        drive("R4 field top bit", 3'd1, 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_4000);
        // R5: isolate lowest
        drive("R5 isolate", 3'd2, 1'b1, 64'h0000_0100_0F00_0000, 64'h0);
        drive("R5 isolate zero", 3'd2, 1'b1, 64'h0, 64'h0);
        drive("R5 isolate top", 3'd2, 1'b1, 64'h8000_0000_0000_0000, 64'h0);
        // R6: mask to lowest
        drive("R6 mask", 3'd3, 1'b1, 64'h0000_0000_0000_0A00, 64'h0);
        drive("R6 mask zero wide", 3'd3, 1'b1, 64'h0, 64'h0);
        drive("R6 mask zero narrow", 3'd3, 1'b0, 64'hFFFF_0000_0000_0000, 64'h0);
        // R7: clear lowest
        drive("R7 clear", 3'd4, 1'b1, 64'hC000_0000_0000_0010, 64'h0);
        drive("R7 clear single", 3'd4, 1'b1, 64'h0000_0000_0000_0004, 64'h0);
        drive("R7 clear zero", 3'd4, 1'b1, 64'h0, 64'h0);
        // R8: narrow lane
        drive("R8 narrow andnot", 3'd0, 1'b0, 64'h1111_0000_0000_FFFF, 64'hFFFF_FFFF_FFFF_0000);
        drive("R8 narrow isolate sign", 3'd2, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'h0);
        drive("R8 narrow clear", 3'd4, 1'b0, 64'h0000_0001_0000_0000, 64'h0);
        // R11: unused codes
        drive("R11 op5", 3'd5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234);
        drive("R11 op6", 3'd6, 1'b0, 64'h1, 64'h1);
        drive("R11 op7", 3'd7, 1'b1, 64'h0, 64'h0);
        // R9: gaps hold the last result
        idle(3);
        drive("R9 after gap", 3'd3, 1'b0, 64'h0000_0000_0000_0100, 64'h0);
        idle(2);

        // Mixed random traffic
        for (int n = 0; n < 400; n++) begin
            logic [63:0] b;
            b = {$urandom, $urandom};
            if (n % 3 == 0) b[15:0] = {8'($urandom_range(0, 70)), 8'($urandom_range(0, 70))};
            drive("R2 R5 R6 R7 random", 3'($urandom_range(0, 7)), 1'($urandom),
                  (n % 5 == 0) ? 64'h0 : {$urandom, $urandom}, b);
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(3);
        check("R9 all requests answered", {36'b0, 32'(exp_q.size())}, 68'b0);
        done = 1'b1;
        finish_run();
    end

endmodule